// File: doc/BRIEF.md
# Multicore Run-Control and Barrier Unit

This unit decides, cycle by cycle, which cores of a small multiprocessor may advance. It keeps a single run flag per core. A core's pipeline advances only while its `run_en` bit is high. Each core can send four kinds of request strobe:

- **wait**: stop until signalled.
- **signal**: wake one target core.
- **barrier**: stop until every core has stopped.
- **halt**: stop for good, unless a later signal revives it.

The unit also drives a fixed identity value to each core, so that one shared program can branch per core. It also forms the interrupt vector address for a chosen core and interrupt line.

The rules for one cycle are applied in this order. First, every request from a running core that clears a flag is applied. Next, the number of cleared flags is counted. If a barrier request is present and every flag is now clear, all flags are set again. Last, signal sets are ORed in. A wake-up signal is not stored: if its target is already running, the signal is lost.

Each cycle's update falls into one of three named kinds (`upd_e`), and the next value of the flag register is chosen from them:

- **UPD_HOLD**: nothing changes.
- **UPD_CHANGE**: the kept flags, ORed with the signal set mask.
- **UPD_RELEASE**: the barrier releases and all flags are set.

Top module: `rc_run_ctrl`

## Requirements
- R1: After reset every bit of `run_en` is 1.
- R2: Lane k of `core_id` (bits k*TW +: TW) always carries the value k.
- R3: A wait strobe from running core k makes `run_en[k]` 0 on the next cycle, unless that core is signalled in the same cycle.
- R4: A signal strobe from a running core with target c makes `run_en[c]` 1 on the next cycle when it was 0.
- R5: A signal to a core that is already running leaves every flag unchanged and is not remembered. A later wait by that core still stops it.
- R6: A halt strobe from running core k clears `run_en[k]`. A later signal to k resumes it.
- R7: A barrier strobe clears the caller's flag. When, after all clears of that cycle, every flag is 0, all flags are 1 on the next cycle. Halted and waiting cores count as arrived.
- R8: A barrier does not release while any other core's flag is still 1.
- R9: A wait by core c and a signal to core c in the same cycle leave core c running.
- R10: Every strobe from a core whose flag is 0 is ignored.
- R11: `vec_addr` = 1000 + 4*`irq_core` + `irq_line`, with `irq_line` in 0..3.
- R12: A signal whose target index is NC or more changes no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wait_req | input | NC | Per-core wait-for-signal strobe |
| sig_req | input | NC | Per-core signal strobe |
| sig_tgt | input | NC*TW | Per-core signal target index, lane k at k*TW |
| bar_req | input | NC | Per-core barrier strobe |
| halt_req | input | NC | Per-core halt strobe |
| run_en | output | NC | Per-core run enable (the run flags) |
| core_id | output | NC*TW | Per-core identity value, lane k at k*TW |
| irq_core | input | TW | Core index for the vector lookup |
| irq_line | input | 2 | Interrupt line for the vector lookup |
| vec_addr | output | AW | Interrupt vector address |

## Verification
The assertions assume that reset is held low for at least one clock edge before any strobe. They also assume that strobes are sampled only on clock edges, so that every flag change can be traced to a set mask, a release or a clear from the previous cycle.

The bench drives all strobes on the falling edge and holds reset for several cycles. It does send strobes from stopped cores and out-of-range targets on purpose, because the unit must mask these. The scenarios cover alternating wait and signal between two cores, a dropped signal, a barrier where the slowest core arrives last, and a barrier completed by halted cores.

// File: rtl/rc_pkg.sv
package rc_pkg;
    typedef enum logic [1:0] {
        UPD_HOLD    = 2'd0,
        UPD_CHANGE  = 2'd1,
        UPD_RELEASE = 2'd2
    } upd_e;

    localparam int IRQ_LINES = 4;
endpackage

// File: rtl/rc_zero_count.sv
module rc_zero_count #(
    parameter int N = 4,
    localparam int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  flags,
    output logic [CW-1:0] zeros
);
    always_comb begin
        zeros = '0;
        for (int i = 0; i < N; i++) begin
            if (!flags[i]) zeros = zeros + CW'(1);
        end
    end
endmodule

// File: rtl/rc_sig_decode.sv
module rc_sig_decode #(
    parameter int NC = 4,
    parameter int TW = 2
) (
    input  logic [NC-1:0]    sig_valid,
    input  logic [NC*TW-1:0] sig_tgt,
    output logic [NC-1:0]    set_mask
);
    for (genvar c = 0; c < NC; c++) begin : g_tgt
        always_comb begin
            set_mask[c] = 1'b0;
            for (int k = 0; k < NC; k++) begin
                if (sig_valid[k] && (sig_tgt[k*TW +: TW] == TW'(c)))
                    set_mask[c] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rc_vec_gen.sv
module rc_vec_gen #(
    parameter int TW       = 2,
    parameter int AW       = 16,
    parameter int VEC_BASE = 1000
) (
    input  logic [TW-1:0] irq_core,
    input  logic [1:0]    irq_line,
    output logic [AW-1:0] vec_addr
);
    localparam int LINES_LOG = $clog2(rc_pkg::IRQ_LINES);

    always_comb begin
        vec_addr = AW'(VEC_BASE) + (AW'(irq_core) << LINES_LOG) + AW'(irq_line);
    end
endmodule

// File: rtl/rc_run_ctrl.sv
module rc_run_ctrl #(
    parameter int NC       = 4,
    parameter int AW       = 16,
    parameter int VEC_BASE = 1000,
    localparam int TW = (NC > 1) ? $clog2(NC) : 1,
    localparam int CW = $clog2(NC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NC-1:0]    wait_req,
    input  logic [NC-1:0]    sig_req,
    input  logic [NC*TW-1:0] sig_tgt,
    input  logic [NC-1:0]    bar_req,
    input  logic [NC-1:0]    halt_req,
    output logic [NC-1:0]    run_en,
    output logic [NC*TW-1:0] core_id,
    input  logic [TW-1:0]    irq_core,
    input  logic [1:0]       irq_line,
    output logic [AW-1:0]    vec_addr
);
    import rc_pkg::*;

    logic [NC-1:0] flags_q, flags_d;
    logic [NC-1:0] v_wait, v_sig, v_bar, v_halt;
    logic [NC-1:0] clr_mask, kept, set_mask;
    logic [CW-1:0] zero_cnt;
    logic          release_all;
    upd_e          upd;

    // Only running cores may issue requests
    assign v_wait = wait_req & flags_q;
    assign v_sig  = sig_req  & flags_q;
    assign v_bar  = bar_req  & flags_q;
    assign v_halt = halt_req & flags_q;

    // Step 1: clears
    assign clr_mask = v_wait | v_bar | v_halt;
    assign kept     = flags_q & ~clr_mask;

    // Step 2: barrier count on the flags after clears
    rc_zero_count #(.N(NC)) u_zero (
        .flags (kept),
        .zeros (zero_cnt)
    );
    assign release_all = (|v_bar) && (zero_cnt == CW'(NC));

    // Step 3: signal sets
    rc_sig_decode #(.NC(NC), .TW(TW)) u_sig (
        .sig_valid (v_sig),
        .sig_tgt   (sig_tgt),
        .set_mask  (set_mask)
    );

    always_comb begin
        if (release_all)                    upd = UPD_RELEASE;
        else if ((clr_mask | set_mask) != '0) upd = UPD_CHANGE;
        else                                upd = UPD_HOLD;
    end

    always_comb begin
        unique case (upd)
            UPD_HOLD:    flags_d = flags_q;
            UPD_CHANGE:  flags_d = kept | set_mask;
            UPD_RELEASE: flags_d = '1;
            default:     flags_d = flags_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '1;
        else        flags_q <= flags_d;
    end

    assign run_en = flags_q;

    for (genvar k = 0; k < NC; k++) begin : g_id
        assign core_id[k*TW +: TW] = TW'(k);
    end

    rc_vec_gen #(.TW(TW), .AW(AW), .VEC_BASE(VEC_BASE)) u_vec (
        .irq_core (irq_core),
        .irq_line (irq_line),
        .vec_addr (vec_addr)
    );

    // R7: a barrier release sets every flag
    a_r7_release_all: assert property (@(posedge clk) disable iff (!rst_n)
        release_all |=> (&run_en));

    for (genvar k = 0; k < NC; k++) begin : g_chk
        // R3: a wait from a running core stops it
        a_r3_wait_stops: assert property (@(posedge clk) disable iff (!rst_n)
            (wait_req[k] && run_en[k] && !set_mask[k] && !release_all) |=> !run_en[k]);
        // R4: a decoded signal leaves the target running
        a_r4_sig_wakes: assert property (@(posedge clk) disable iff (!rst_n)
            set_mask[k] |=> run_en[k]);
        // R10: a stopped core stays stopped without a wake source
        a_r10_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_en[k] && !set_mask[k] && !release_all) |=> !run_en[k]);
        // R4/R7: every restart has a cause
        a_r4_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(run_en[k]) |-> $past(set_mask[k] || release_all));
    end
endmodule

// File: tb/rc_run_ctrl_tb.sv
module rc_run_ctrl_tb;
    localparam int NC = 3;
    localparam int TW = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NC-1:0]   wait_req = '0, sig_req = '0, bar_req = '0, halt_req = '0;
    logic [NC*TW-1:0] sig_tgt = '0;
    logic [NC-1:0]   run_en;
    logic [NC*TW-1:0] core_id;
    logic [TW-1:0]   irq_core = '0;
    logic [1:0]      irq_line = '0;
    logic [15:0]     vec_addr;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [NC-1:0] exp_q[$];
    string         tag_q[$];

    rc_run_ctrl #(.NC(NC), .AW(16), .VEC_BASE(1000)) u_dut (
        .clk(clk), .rst_n(rst_n), .wait_req(wait_req), .sig_req(sig_req),
        .sig_tgt(sig_tgt), .bar_req(bar_req), .halt_req(halt_req),
        .run_en(run_en), .core_id(core_id), .irq_core(irq_core),
        .irq_line(irq_line), .vec_addr(vec_addr)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Driver: one request cycle, expected flags pushed to the scoreboard
    task automatic step(input logic [2:0] w, input logic [2:0] s,
                        input logic [1:0] t0, input logic [1:0] t1, input logic [1:0] t2,
                        input logic [2:0] b, input logic [2:0] h,
                        input logic [2:0] e, input string tag);
        @(negedge clk);
        wait_req = w; sig_req = s; bar_req = b; halt_req = h;
        sig_tgt = {t2, t1, t0};
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input logic [2:0] e, input string tag);
        step(3'b000, 3'b000, 2'd0, 2'd0, 2'd0, 3'b000, 3'b000, e, tag);
    endtask

    // Monitor: compares one cycle after each driven request
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [NC-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, int'(run_en), int'(e));
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        n_bad++;
        n_cmp++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        chk("R1 reset flags", int'(run_en), 7);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 after release", int'(run_en), 7);

        // R2 identity lanes
        for (int k = 0; k < NC; k++) chk("R2 core_id", int'(core_id[k*TW +: TW]), k);

        // R11 vector addresses
        irq_core = 2'd0; irq_line = 2'd0; #1; chk("R11 vec c0 l0", int'(vec_addr), 1000);
        irq_core = 2'd2; irq_line = 2'd1; #1; chk("R11 vec c2 l1", int'(vec_addr), 1009);
        irq_core = 2'd1; irq_line = 2'd3; #1; chk("R11 vec c1 l3", int'(vec_addr), 1007);

        // Alternation between cores 0 and 1 (R3, R4)
        for (int i = 0; i < 3; i++) begin
            step(3'b001, 3'b000, 0, 0, 0, 3'b000, 3'b000, 3'b110, "R3 core0 waits");
            step(3'b000, 3'b010, 0, 0, 0, 3'b000, 3'b000, 3'b111, "R4 core1 wakes core0");
            step(3'b010, 3'b000, 0, 0, 0, 3'b000, 3'b000, 3'b101, "R3 core1 waits");
            step(3'b000, 3'b001, 1, 0, 0, 3'b000, 3'b000, 3'b111, "R4 core0 wakes core1");
        end

        // R5 dropped signal
        step(3'b000, 3'b010, 0, 0, 0, 3'b000, 3'b000, 3'b111, "R5 signal to running core");
        step(3'b001, 3'b000, 0, 0, 0, 3'b000, 3'b000, 3'b110, "R5 wait after dropped signal");
        idle(3'b110, "R5 not remembered");
        step(3'b000, 3'b100, 0, 0, 0, 3'b000, 3'b000, 3'b111, "R4 core2 wakes core0");

        // R9 same-cycle wait and signal
        step(3'b001, 3'b010, 0, 0, 0, 3'b000, 3'b000, 3'b111, "R9 wait+signal same cycle");

        // R10 masking of stopped cores
        step(3'b100, 3'b000, 0, 0, 0, 3'b000, 3'b000, 3'b011, "R3 core2 waits");
        step(3'b001, 3'b000, 0, 0, 0, 3'b000, 3'b000, 3'b010, "R3 core0 waits");
        step(3'b000, 3'b001, 2, 0, 0, 3'b001, 3'b000, 3'b010, "R10 stopped core requests");
        step(3'b000, 3'b010, 0, 0, 0, 3'b000, 3'b000, 3'b011, "R4 core1 wakes core0");
        step(3'b000, 3'b010, 0, 2, 0, 3'b000, 3'b000, 3'b111, "R4 core1 wakes core2");

        // R12 out-of-range target
        step(3'b010, 3'b000, 0, 0, 0, 3'b000, 3'b000, 3'b101, "R3 core1 waits");
        step(3'b000, 3'b001, 3, 0, 0, 3'b000, 3'b000, 3'b101, "R12 target 3 ignored");
        step(3'b000, 3'b001, 1, 0, 0, 3'b000, 3'b000, 3'b111, "R4 core0 wakes core1");

        // R6 halt then revive
        step(3'b000, 3'b000, 0, 0, 0, 3'b000, 3'b100, 3'b011, "R6 core2 halts");
        idle(3'b011, "R6 halted stays");
        step(3'b000, 3'b001, 2, 0, 0, 3'b000, 3'b000, 3'b111, "R6 signal revives halted");

        // R7/R8 barrier with core2 slowest
        step(3'b000, 3'b000, 0, 0, 0, 3'b001, 3'b000, 3'b110, "R7 barrier clears own");
        step(3'b000, 3'b000, 0, 0, 0, 3'b010, 3'b000, 3'b100, "R8 no release yet");
        idle(3'b100, "R8 still waiting");
        step(3'b000, 3'b000, 0, 0, 0, 3'b100, 3'b000, 3'b111, "R7 slowest releases");

        // R7 halted core counts as arrived
        step(3'b000, 3'b000, 0, 0, 0, 3'b000, 3'b100, 3'b011, "R6 core2 halts");
        step(3'b000, 3'b000, 0, 0, 0, 3'b001, 3'b000, 3'b010, "R8 barrier core0");
        step(3'b000, 3'b000, 0, 0, 0, 3'b010, 3'b000, 3'b111, "R7 release with halted");

        // R7 all arrive in one cycle
        step(3'b000, 3'b000, 0, 0, 0, 3'b111, 3'b000, 3'b111, "R7 simultaneous barrier");
        idle(3'b111, "R7 stays running");

        while (exp_q.size() > 0) @(posedge clk);
        @(posedge clk);
        #1;
        finish_run();
    end
endmodule